// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked request source and an asynchronous 256K x 16 static RAM that has separate active-low controls for its upper and lower byte lanes. A requester presents a word address, a write flag, write data and a two-bit byte mask over a valid/ready handshake. The controller turns each accepted request into a fixed pin sequence: chip select, write strobe or output enable, the two byte strobes, and a split data bus (data out, data in and a drive enable) that an I/O ring merges into the bidirectional pins.

Access length is fixed by two parameters: `RD_WAIT` is the number of clocks the memory has from address/select to sampled read data, and `WR_WAIT` is the number of clocks the write strobe stays low. They are chosen so that `RD_WAIT` clock periods cover the address access time of the memory's speed grade (8, 10, 12 or 15 ns) and `WR_WAIT` periods cover its write pulse. A write ends with one hold clock in which the write strobe is high but address and data stay put. The memory needs no refresh and the controller never issues a cycle of its own.

Back-pressure rules: the request side follows valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high; while `req_ready` is low the requester keeps `req_valid` and the request fields unchanged, and the controller ignores them. `req_ready` is high only while the controller is idle, so one access is in flight at a time. The read-data side has no ready: `rd_valid` is a one-clock pulse that the consumer must take when it appears.

Top module: `sram_ctrl`

## Requirements
- R1: While idle and during reset, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are all 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 exactly in idle clocks; a request is accepted on an edge where `req_valid` and `req_ready` are both 1, and `req_valid` during a busy clock has no effect on the pins or on later accesses.
- R3: For an accepted write (`req_write`=1), from the clock after acceptance and for `WR_WAIT` clocks, `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_out` equals the request's write data.
- R4: For every access, read or write, throughout the access `mem_lb_n` = NOT `req_mask[0]` (bits 7:0) and `mem_ub_n` = NOT `req_mask[1]` (bits 15:8); with mask 00 a write changes no memory bit.
- R5: Each write ends with exactly one hold clock with `mem_ce_n`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=1 and address and `mem_dq_out` unchanged, followed by an idle clock.
- R6: For an accepted read, from the clock after acceptance and for `RD_WAIT` clocks, `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0; then the controller is idle.
- R7: `mem_dq_in` is sampled at the end of the last read clock; in the next clock `rd_valid` is 1 for exactly one clock and `rd_data` holds the sampled lanes, with each lane whose mask bit was 0 forced to zero.
- R8: `mem_dq_oe`=1 and `mem_oe_n`=0 never occur in the same clock, and the clock before `mem_oe_n` falls always has `mem_dq_oe`=0.
- R9: `mem_addr` equals the accepted request's address and stays constant for every clock in which `mem_ce_n` is 0 within one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-clock read data pulse |
| rd_data | output | 16 | Read data, deselected lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper-lane strobe, active low |
| mem_lb_n | output | 1 | Lower-lane strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data read from the memory pins |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
The bench goes after a write followed at once by a read, where a controller that released the data bus late or opened the output enable early would show drive enable and output enable low together. It walks all four byte masks on both reads and writes, including mask 00, so a swapped or inverted lane map shows up as the wrong lane changing in a later read, and a design that forwarded floating lanes would return the bus filler pattern instead of zero. It holds `req_valid` through busy periods, which a controller that accepted early would turn into doubled or shifted pin sequences, and checks that the read-data pulse lands one clock after the last read clock and never lasts two.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_HOLD  = 2'd2,
    PH_READ  = 2'd3
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pin_ctl_t;

  localparam pin_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

  function automatic pin_ctl_t phase_pins(phase_e ph);
    pin_ctl_t c;
    c = CTL_IDLE;
    case (ph)
      PH_WRITE: c = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      PH_HOLD:  c = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
      PH_READ:  c = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      default:  c = CTL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  output logic     ready,
  output logic     accept,
  output logic     rd_last,
  output logic     nxt_idle,
  output pin_ctl_t ctl
);

  localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);
  localparam logic [CNT_W-1:0] RD_END = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_END = CNT_W'(WR_WAIT - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ready  = (ph_q == PH_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    rd_last = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (req_valid) ph_d = req_write ? PH_WRITE : PH_READ;
      end
      PH_WRITE: begin
        if (cnt_q == WR_END) begin
          ph_d  = PH_HOLD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: ph_d = PH_IDLE;
      PH_READ: begin
        if (cnt_q == RD_END) begin
          ph_d    = PH_IDLE;
          cnt_d   = '0;
          rd_last = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign nxt_idle = (ph_d == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ctl   <= CTL_IDLE;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      ctl   <= phase_pins(ph_d);
    end
  end

endmodule

// File: rtl/sram_ctrl_lane.sv
`timescale 1ns/1ps
module sram_ctrl_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              keep,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (capture) begin
      dout <= keep ? din : '0;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LANE_W  = 8,
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_mask,
  output logic                  rd_valid,
  output logic [2*LANE_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic                  mem_ub_n,
  output logic                  mem_lb_n,
  output logic [2*LANE_W-1:0]   mem_dq_out,
  input  logic [2*LANE_W-1:0]   mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic            accept, rd_last, nxt_idle;
  pin_ctl_t        ctl;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  strobe_n_q;
  logic              rd_valid_q;

  sram_ctrl_seq #(
    .RD_WAIT (RD_WAIT),
    .WR_WAIT (WR_WAIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ready     (req_ready),
    .accept    (accept),
    .rd_last   (rd_last),
    .nxt_idle  (nxt_idle),
    .ctl       (ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      strobe_n_q <= '1;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_last;
      if (accept) begin
        addr_q     <= req_addr;
        wdata_q    <= req_wdata;
        mask_q     <= req_mask;
        strobe_n_q <= ~req_mask;
      end else if (nxt_idle) begin
        strobe_n_q <= '1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_ctrl_lane #(.LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rd_last),
      .keep    (mask_q[g]),
      .din     (mem_dq_in[g*LANE_W +: LANE_W]),
      .dout    (rd_data[g*LANE_W +: LANE_W])
    );
  end

  assign rd_valid   = rd_valid_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = ctl.ce_n;
  assign mem_oe_n   = ctl.oe_n;
  assign mem_we_n   = ctl.we_n;
  assign mem_dq_oe  = ctl.drive;
  assign mem_dq_out = wdata_q;
  assign mem_lb_n   = strobe_n_q[0];
  assign mem_ub_n   = strobe_n_q[1];

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  // R3
  strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R5
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(2*LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_ub_n   (mem_ub_n),
  .mem_lb_n   (mem_lb_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  localparam int AW  = 18;
  localparam int DW  = 16;
  localparam int RDW = 3;
  localparam int WRW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  always #2.5 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .LANE_W(8), .RD_WAIT(RDW), .WR_WAIT(WRW)) i_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fill_word(logic [AW-1:0] a);
    return 16'(a * 7) ^ 16'h1234;
  endfunction

  // ---------------- memory device model (pin side) ----------------
  logic [DW-1:0] dev_mem [int];

  function automatic logic [DW-1:0] dev_get(logic [AW-1:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : fill_word(a);
  endfunction

  always @(*) begin
    logic [DW-1:0] w;
    mem_dq_in = 16'hA5A5;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      w = dev_get(mem_addr);
      if (!mem_lb_n) mem_dq_in[7:0]  = w[7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = w[15:8];
    end
  end

  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [DW-1:0] w;
      w = dev_get(mem_addr);
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      dev_mem[int'(mem_addr)] = w;
    end
  end

  // ---------------- reference model (request side) ----------------
  typedef struct {
    int            kind;   // 0 idle, 1 write strobe, 2 write hold, 3 read
    bit            last;
    logic [1:0]    be_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [DW-1:0] rexp;
  } ent_t;

  ent_t          plan_q[$];
  ent_t          cur;
  logic [DW-1:0] ref_mem [int];
  bit            exp_rv;
  logic [DW-1:0] exp_rd;

  function automatic ent_t idle_ent();
    ent_t e;
    e.kind = 0; e.last = 0; e.be_n = 2'b11; e.addr = '0; e.wd = '0; e.rexp = '0;
    return e;
  endfunction

  function automatic logic [DW-1:0] ref_get(logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill_word(a);
  endfunction

  task automatic plan_request();
    ent_t e;
    logic [DW-1:0] w;
    e = idle_ent();
    e.be_n = ~req_mask;
    e.addr = req_addr;
    e.wd   = req_wdata;
    w = ref_get(req_addr);
    if (req_write) begin
      if (req_mask[0]) w[7:0]  = req_wdata[7:0];
      if (req_mask[1]) w[15:8] = req_wdata[15:8];
      ref_mem[int'(req_addr)] = w;
      for (int i = 0; i < WRW; i++) begin e.kind = 1; plan_q.push_back(e); end
      e.kind = 2; plan_q.push_back(e);
    end else begin
      e.rexp = {req_mask[1] ? w[15:8] : 8'h00, req_mask[0] ? w[7:0] : 8'h00};
      for (int i = 0; i < RDW; i++) begin
        e.kind = 3; e.last = (i == RDW - 1); plan_q.push_back(e);
      end
    end
  endtask

  initial cur = idle_ent();

  always @(posedge clk) begin
    if (!rst_n) begin
      plan_q.delete();
      cur = idle_ent();
      exp_rv = 0;
    end else begin
      exp_rv = (cur.kind == 3) && cur.last;
      exp_rd = cur.rexp;
      if (cur.kind == 0 && req_valid) plan_request();
      cur = (plan_q.size() != 0) ? plan_q.pop_front() : idle_ent();
    end
  end

  // ---------------- per-clock comparison ----------------
  logic prev_oe_n = 1'b1;
  logic prev_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] pins;
      pins = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
      chk(req_ready == (cur.kind == 0), "R2 ready", req_ready, cur.kind == 0);
      case (cur.kind)
        0: chk({pins, mem_ub_n, mem_lb_n} == 6'b111011, "R1 idle pins",
               {pins, mem_ub_n, mem_lb_n}, 6'b111011);
        1: begin
          chk(pins == 4'b0101, "R3 write strobe pins", pins, 4'b0101);
          chk(mem_dq_out == cur.wd, "R3 write data", mem_dq_out, cur.wd);
        end
        2: begin
          chk(pins == 4'b0111, "R5 hold pins", pins, 4'b0111);
          chk(mem_dq_out == cur.wd, "R5 hold data", mem_dq_out, cur.wd);
        end
        default: chk(pins == 4'b0010, "R6 read pins", pins, 4'b0010);
      endcase
      if (cur.kind != 0) begin
        chk({mem_ub_n, mem_lb_n} == cur.be_n, "R4 byte strobes", {mem_ub_n, mem_lb_n}, cur.be_n);
        chk(mem_addr == cur.addr, "R9 address", mem_addr, cur.addr);
      end
      chk(rd_valid == exp_rv, "R7 rd_valid", rd_valid, exp_rv);
      if (exp_rv) chk(rd_data == exp_rd, "R7 rd_data", rd_data, exp_rd);
      chk(!(mem_dq_oe && !mem_oe_n), "R8 bus contention", {mem_dq_oe, mem_oe_n}, 2'b00);
      if (prev_oe_n && !mem_oe_n)
        chk(!prev_dq_oe, "R8 turnaround gap", prev_dq_oe, 1'b0);
      prev_oe_n  = mem_oe_n;
      prev_dq_oe = mem_dq_oe;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] m, int gap);
    bit acc;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    forever begin
      acc = req_ready;
      @(posedge clk);
      @(negedge clk);
      if (acc) break;
    end
    req_valid = 1'b0;
    req_write = $urandom_range(0, 1);
    req_wdata = 16'($urandom);
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
        7'b1111110);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4/R7: full-word write and readback, then each single lane
    send(1, 18'h00010, 16'h1234, 2'b11, 0);
    send(0, 18'h00010, 16'h0000, 2'b11, 1);
    send(1, 18'h00010, 16'hABCD, 2'b01, 0);   // lower lane only
    send(0, 18'h00010, 16'h0000, 2'b11, 0);   // expect 12CD
    send(1, 18'h00010, 16'h77EE, 2'b10, 2);   // upper lane only -> 77CD
    send(1, 18'h00010, 16'hFFFF, 2'b00, 0);   // R4: mask 00 writes nothing
    send(0, 18'h00010, 16'h0000, 2'b11, 0);
    send(0, 18'h00010, 16'h0000, 2'b01, 0);   // R7: upper forced zero
    send(0, 18'h00010, 16'h0000, 2'b10, 0);   // R7: lower forced zero
    send(0, 18'h00010, 16'h0000, 2'b00, 0);   // R7: both zero
    // R9: top and bottom of the address range, R8: write then read at once
    send(1, 18'h3FFFF, 16'hC3A5, 2'b11, 0);
    send(0, 18'h3FFFF, 16'h0000, 2'b11, 0);
    send(1, 18'h00000, 16'h5AA5, 2'b11, 0);
    send(0, 18'h00000, 16'h0000, 2'b11, 0);
    send(0, 18'h00123, 16'h0000, 2'b11, 0);   // never written: fill pattern
    send(1, 18'h00123, 16'h0F0F, 2'b11, 0);   // read then write at once

    // R2: mixed traffic with valid held through busy periods
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 3))
        0: a = 18'h3FFFF;
        1: a = 18'h00000;
        default: a = 18'($urandom_range(0, 15));
      endcase
      send($urandom_range(0, 1), a, 16'($urandom), 2'($urandom_range(0, 3)),
           $urandom_range(0, 2));
    end

    repeat (RDW + WRW + 4) @(negedge clk);
    finish_run();
  end

endmodule